// File: doc/BRIEF.md
# Write-Only I2C Receiver for a DAC Code Register

This block is a receive-only I2C target that feeds a single-channel digital-to-analog converter. It samples the bus lines with the system clock and finds START and STOP conditions. A write frame carries a 7-bit address and then two data bytes. From these bytes it builds an N-bit converter code (N is 12, 10 or 8) and holds it in an output register. The register updates once per complete frame, and a one-cycle strobe marks each update.

The block only pulls SDA low, through an output enable, and only to acknowledge a byte. It never sends data. A read request, a frame for another address and any byte after the second data byte all get no acknowledge. The block then ignores the bus until the next START.

At reset the code register holds zero-scale, or mid-scale when a parameter asks for it. The analog stage, the reference and the bus pull-ups are outside this block.

Top module: `i2c_dac_rx`

## Requirements
- R1: After reset `dac_code` is all zeros when `MID_RESET` is 0. When `MID_RESET` is 1, only its most significant bit is set. `code_valid` and `sda_oe` are low after reset.
- R2: A falling SDA while SCL is high is a START. It abandons any transfer in progress, including a partly received byte, and the next 8 bits are taken as a new address byte.
- R3: A rising SDA while SCL is high is a STOP. It returns the block to idle, and `sda_oe` stays low until a later START.
- R4: An address byte whose bits 7:1 equal `DEV_ADDR` and whose bit 0 (direction) is 0 is acknowledged. `sda_oe` rises after the SCL fall that ends the 8th bit and falls after the SCL fall that ends the 9th pulse, so SDA stays low for the whole high phase of the 9th pulse.
- R5: An address byte with bit 0 equal to 1 (read) is not acknowledged. Every later byte up to the next START is also left without acknowledge, and `dac_code` does not change.
- R6: An address byte whose bits 7:1 differ from `DEV_ADDR` is not acknowledged, and the block ignores all bytes until the next START.
- R7: Bits are sampled on SCL rising edges, most significant bit first. The first data byte is the upper half and the second data byte the lower half of a 16-bit word. The new code is the top `CODE_W` bits of that word, and both data bytes are acknowledged.
- R8: `code_valid` is a single-cycle pulse that follows the SCL fall ending the acknowledge of the second data byte. `dac_code` takes its new value in that same cycle and changes at no other time.
- R9: A third and any later data byte in the same frame is not acknowledged and leaves `dac_code` unchanged.
- R10: A frame that a STOP ends before the second data byte is acknowledged leaves `dac_code` unchanged and produces no `code_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| dac_code | output | CODE_W | Converter input code |
| code_valid | output | 1 | One-cycle strobe on each code update |

## Verification
On every cycle, the embedded properties check these rules:
- `code_valid` lasts one cycle, and `dac_code` moves only with it.
- `sda_oe` switches only while the synchronised SCL is low.
- A STOP leaves the line released.
- A read address or a third data byte never leads to an acknowledge.

Only the bench's scenarios can show the rest:
- the exact value assembled from two bytes for 12-bit and 8-bit widths;
- the choice between the zero-scale and mid-scale reset values;
- aborts by repeated START in mid-byte and by an early STOP;
- two targets on one bus staying out of each other's frames.

// File: rtl/i2c_dac_rx.sv
module i2c_dac_rx #(
  parameter logic [6:0] DEV_ADDR  = 7'h4A,
  parameter int         CODE_W    = 12,
  parameter bit         MID_RESET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_valid
);

  localparam logic [CODE_W-1:0] RESET_CODE =
    MID_RESET ? {1'b1, {(CODE_W-1){1'b0}}} : {CODE_W{1'b0}};
  localparam int DROP = 16 - CODE_W;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACK, S_SKIP} state_t;

  state_t     state;
  logic [2:0] scl_q, sda_q;
  logic [3:0] bit_cnt;
  logic [1:0] byte_idx;
  logic [7:0] shreg, msb_q;
  logic [15:0] word;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];

  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire byte_end  = (state == S_RECV) && scl_fall && (bit_cnt == 4'd8);

  wire accept = (byte_idx == 2'd0) ? (shreg[7:1] == DEV_ADDR && !shreg[0])
                                   : (byte_idx != 2'd3);

  assign word   = {msb_q, shreg};
  assign sda_oe = (state == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      msb_q      <= '0;
      dac_code   <= RESET_CODE;
      code_valid <= 1'b0;
    end else begin
      code_valid <= 1'b0;
      if (start_det) begin
        state    <= S_RECV;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (stop_det) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_RECV: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              bit_cnt <= '0;
              state   <= accept ? S_ACK : S_SKIP;
              if (byte_idx == 2'd1) msb_q <= shreg;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (byte_idx == 2'd2) begin
                dac_code   <= CODE_W'(word >> DROP);
                code_valid <= 1'b1;
              end
              byte_idx <= byte_idx + 2'd1;
              state    <= S_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> $stable(dac_code));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R4
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_s || $past(start_det || stop_det)));

  // R5
  read_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && byte_idx == 2'd0 && shreg[0]) |=> !sda_oe);

  // R9
  extra_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && byte_idx == 2'd3) |=> !sda_oe);

endmodule

// File: tb/sim_i2c_dac_rx.sv
module sim_i2c_dac_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'h4A;
  localparam logic [6:0] A1 = 7'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic oe0, oe1, v0, v1;
  logic [11:0] code0;
  logic [7:0]  code1;
  wire sda_line = sda_m & ~oe0 & ~oe1;

  int n_chk = 0, n_fail = 0, pulses = 0, pushes = 0;
  bit done = 1'b0;
  logic [11:0] q0[$];
  logic [7:0]  q1[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dac_rx #(.DEV_ADDR(A0), .CODE_W(12), .MID_RESET(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(oe0), .dac_code(code0), .code_valid(v0));

  i2c_dac_rx #(.DEV_ADDR(A1), .CODE_W(8), .MID_RESET(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(oe1), .dac_code(code1), .code_valid(v1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic v0_d = 1'b0, v1_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (v0 && v0_d) chk(1'b0, "R8 u0 valid wider than one cycle", 2, 1);
      if (v1 && v1_d) chk(1'b0, "R8 u1 valid wider than one cycle", 2, 1);
      if (v0) begin
        pulses++;
        if (q0.size() == 0) chk(1'b0, "R8 u0 unexpected update", int'(code0), 0);
        else begin
          logic [11:0] e;
          e = q0.pop_front();
          chk(code0 == e, "R7 u0 code", int'(code0), int'(e));
        end
      end
      if (v1) begin
        pulses++;
        if (q1.size() == 0) chk(1'b0, "R8 u1 unexpected update", int'(code1), 0);
        else begin
          logic [7:0] e;
          e = q1.pop_front();
          chk(code1 == e, "R7 u1 code", int'(code1), int'(e));
        end
      end
    end
    v0_d <= v0;
    v1_d <= v1;
  end

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s1, s2;
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(1);
    s1 = ~sda_line; wt(2*Q-2);
    s2 = ~sda_line; wt(1);
    scl_m = 1'b0; wt(Q);
    chk(s1 == s2, "R4 ack level stable over high phase", int'(s2), int'(s1));
    acked = s1;
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                       output bit k0, output bit k1, output bit k2);
    bus_start();
    send_byte(a, k0);
    send_byte(d0, k1);
    send_byte(d1, k2);
    bus_stop();
    wt(4*Q);
  endtask

  initial begin
    bit k0, k1, k2, k3;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    // R1 reset state of both variants
    chk(code0 == 12'h000, "R1 zero-scale reset", int'(code0), 0);
    chk(code1 == 8'h80, "R1 mid-scale reset", int'(code1), 'h80);
    chk(!oe0 && !oe1 && !v0 && !v1, "R1 outputs idle after reset", int'({oe0,oe1,v0,v1}), 0);

    // R4 R7 R6: write to u0; u1 stays out
    q0.push_back(12'hABC); pushes++;
    frame({A0,1'b0}, 8'hAB, 8'hCD, k0, k1, k2);
    chk(k0, "R4 address acknowledged", int'(k0), 1);
    chk(k1 && k2, "R7 data bytes acknowledged", int'({k1,k2}), 3);
    chk(code0 == 12'hABC, "R7 u0 12-bit code", int'(code0), 'hABC);
    chk(code1 == 8'h80, "R6 other target untouched", int'(code1), 'h80);
    chk(!oe0 && !oe1, "R3 line released after stop", int'({oe0,oe1}), 0);

    // R7 8-bit variant takes first byte
    q1.push_back(8'h5A); pushes++;
    frame({A1,1'b0}, 8'h5A, 8'hFF, k0, k1, k2);
    chk(k0 && k1 && k2, "R7 u1 frame acknowledged", int'({k0,k1,k2}), 7);
    chk(code1 == 8'h5A, "R7 u1 8-bit code", int'(code1), 'h5A);
    chk(code0 == 12'hABC, "R6 u0 untouched by u1 frame", int'(code0), 'hABC);

    // R5 read request
    frame({A0,1'b1}, 8'h00, 8'h00, k0, k1, k2);
    chk(!k0, "R5 read address not acknowledged", int'(k0), 0);
    chk(!k1 && !k2, "R5 later bytes silent", int'({k1,k2}), 0);
    chk(code0 == 12'hABC, "R5 code unchanged after read", int'(code0), 'hABC);

    // R6 address mismatch
    frame({7'h4B,1'b0}, 8'h11, 8'h22, k0, k1, k2);
    chk(!k0 && !k1 && !k2, "R6 mismatched frame silent", int'({k0,k1,k2}), 0);
    chk(code0 == 12'hABC && code1 == 8'h5A, "R6 codes unchanged", int'(code0), 'hABC);

    // R9 extra byte
    q0.push_back(12'h123); pushes++;
    bus_start();
    send_byte({A0,1'b0}, k0);
    send_byte(8'h12, k1);
    send_byte(8'h34, k2);
    send_byte(8'h56, k3);
    bus_stop();
    wt(4*Q);
    chk(!k3, "R9 third data byte not acknowledged", int'(k3), 0);
    chk(code0 == 12'h123, "R9 code keeps two-byte value", int'(code0), 'h123);

    // R10 early stop
    bus_start();
    send_byte({A0,1'b0}, k0);
    send_byte(8'h99, k1);
    bus_stop();
    wt(4*Q);
    chk(k0 && k1, "R10 partial frame bytes acknowledged", int'({k0,k1}), 3);
    chk(code0 == 12'h123, "R10 code unchanged on early stop", int'(code0), 'h123);

    // R2 repeated start in mid-byte
    q0.push_back(12'hFFF); pushes++;
    bus_start();
    send_byte({A0,1'b0}, k0);
    send_bits(8'hA0, 4);
    bus_start();
    send_byte({A0,1'b0}, k0);
    send_byte(8'hFF, k1);
    send_byte(8'hF0, k2);
    bus_stop();
    wt(4*Q);
    chk(k0 && k1 && k2, "R2 frame after restart acknowledged", int'({k0,k1,k2}), 7);
    chk(code0 == 12'hFFF, "R2 code from restarted frame", int'(code0), 'hFFF);

    // R8 scoreboard drained
    chk(pulses == pushes, "R8 one strobe per full frame", pulses, pushes);
    chk(q0.size() == 0 && q1.size() == 0, "R8 all expected updates seen",
        q0.size() + q1.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule